// File: doc/BRIEF.md
# Nibble-Serial Configuration ROM Header CRC

This block computes the 16-bit check value that guards the header of a serial-bus configuration block or map block. A job begins with a one-cycle start pulse that carries the number of 32-bit quadlets the check must cover. The block then takes the quadlets one at a time over a valid/ready handshake. Each accepted quadlet is consumed as eight 4-bit nibbles, one per clock, starting with the most significant nibble.

Each nibble updates the running value with a fixed shift-and-XOR step. This step is equivalent to the polynomial x^16 + x^12 + x^5 + 1, applied four bits at a time. After the last nibble of the last quadlet, the block pulses done for one clock. It also presents the result, both on its own and packed into a ready-made header quadlet: the count sits in the upper half and the check value in the lower half. A topology map would be run with a count of its self-ID quadlets plus two. A speed map would use the fixed count 0x3F1.

Top module: `cfg_crc16_nib`

## Requirements
- R1: After reset, q_ready_o, done_o, crc_o and header_o are all zero.
- R2: A start pulse with a nonzero count clears the running value to zero, discarding any job in progress. In the next cycle q_ready_o is 1 and done_o is 0.
- R3: Nibbles are taken from bits 31:28 down to 3:0. Each step uses s = crc[15:12] XOR nibble, and the new crc is (crc << 4) XOR (s << 12) XOR (s << 5) XOR s, truncated to 16 bits. For example, a single quadlet 0x00000001 yields 0x1021.
- R4: After a quadlet is accepted, q_ready_o stays 0 for exactly eight cycles, one per nibble. q_valid_i and q_data_i are ignored during those cycles.
- R5: done_o is high for exactly one cycle, in the cycle after the last nibble of the last quadlet is processed. crc_o changes only on that edge and holds its value until the next result. After done, q_ready_o is 0.
- R6: header_o holds the job's quadlet count in bits 31:16 and the result in bits 15:0. It is updated together with crc_o.
- R7: A start pulse with a count of zero raises done_o in the next cycle, with crc_o = 0x0000 and header_o = 0x00000000.
- R8: A start pulse arriving while quadlets are being processed restarts the computation. The result depends only on the quadlets accepted after the latest start.
- R9: Idle cycles with q_valid_i low between quadlets do not change the result.
- R10: A job covering 0x3F1 quadlets, the speed-map length, produces the correct check value and header.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | One-cycle pulse that begins a job |
| count_i | input | CNT_W (16) | Number of quadlets in the job, sampled with start_i |
| q_valid_i | input | 1 | Quadlet on q_data_i is valid |
| q_data_i | input | DATA_W (32) | Quadlet, big-endian nibble order |
| q_ready_o | output | 1 | Block can accept a quadlet this cycle |
| done_o | output | 1 | One-cycle pulse: result is valid |
| crc_o | output | 16 | Check value of the last completed job |
| header_o | output | HDR_W (32) | Count in upper half, check value in lower half |

## Verification
The bench builds the block with the default values: 32-bit quadlets, a 16-bit count, a 32-bit header and most-significant-nibble-first order. With the full 16-bit count field, a complete speed-map length of 0x3F1 quadlets can be run and its count checked in the header. The 32-bit quadlet width sets the window of eight not-ready cycles that the bench measures around each handshake. The bench also holds valid high with garbage data during those windows, restarts a job in the middle of a quadlet, and issues a zero-length job.

// File: rtl/cfgcrc_pkg.sv
package cfgcrc_pkg;

   localparam int unsigned NIB_BITS = 4;
   localparam int unsigned CRC_BITS = 16;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_WAIT  = 2'd1,
      ST_SHIFT = 2'd2
   } crc_state_t;

   // One nibble step of the x^16+x^12+x^5+1 check, four bits at a time.
   function automatic logic [CRC_BITS-1:0] crc_nib_step(
      input logic [CRC_BITS-1:0] crc,
      input logic [NIB_BITS-1:0] nib
   );
      logic [3:0] s;
      s = crc[15:12] ^ nib;
      return {crc[11:0], 4'h0} ^ {s, 12'h000} ^ {7'h00, s, 5'h00} ^ {12'h000, s};
   endfunction

endpackage

// File: rtl/cfgcrc_nib_engine.sv
module cfgcrc_nib_engine
   import cfgcrc_pkg::*;
#(
   parameter int unsigned CRC_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr_i,
   input  logic             step_i,
   input  logic [3:0]       nib_i,
   output logic [CRC_W-1:0] acc_nxt_o
);

   logic [CRC_W-1:0] acc_q;

   assign acc_nxt_o = crc_nib_step(acc_q, nib_i);

   always_ff @(posedge clk) begin
      if (!rst_n)
         acc_q <= '0;
      else if (clr_i)
         acc_q <= '0;
      else if (step_i)
         acc_q <= acc_nxt_o;
   end

   // R2: a clear leaves the accumulator at zero
   a_r2_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
      clr_i |=> (acc_q == '0));

   // R9: no step, no change
   a_r9_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr_i && !step_i) |=> $stable(acc_q));

endmodule

// File: rtl/cfgcrc_quad_shift.sv
module cfgcrc_quad_shift #(
   parameter int unsigned DATA_W    = 32,
   parameter bit          MSB_FIRST = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_i,
   input  logic [DATA_W-1:0] data_i,
   input  logic              shift_i,
   output logic [3:0]        nib_o
);

   logic [DATA_W-1:0] sh_q;

   generate
      if (MSB_FIRST) begin : g_msb
         assign nib_o = sh_q[DATA_W-1 -: 4];
         always_ff @(posedge clk) begin
            if (!rst_n)       sh_q <= '0;
            else if (load_i)  sh_q <= data_i;
            else if (shift_i) sh_q <= {sh_q[DATA_W-5:0], 4'h0};
         end
      end else begin : g_lsb
         assign nib_o = sh_q[3:0];
         always_ff @(posedge clk) begin
            if (!rst_n)       sh_q <= '0;
            else if (load_i)  sh_q <= data_i;
            else if (shift_i) sh_q <= {4'h0, sh_q[DATA_W-1:4]};
         end
      end
   endgenerate

endmodule

// File: rtl/cfg_crc16_nib.sv
module cfg_crc16_nib
   import cfgcrc_pkg::*;
#(
   parameter int unsigned DATA_W    = 32,
   parameter int unsigned CNT_W     = 16,
   parameter int unsigned HDR_W     = 32,
   parameter bit          MSB_FIRST = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic [CNT_W-1:0]  count_i,
   input  logic              q_valid_i,
   input  logic [DATA_W-1:0] q_data_i,
   output logic              q_ready_o,
   output logic              done_o,
   output logic [15:0]       crc_o,
   output logic [HDR_W-1:0]  header_o
);

   localparam int unsigned CRC_W    = CRC_BITS;
   localparam int unsigned NIBS     = DATA_W / NIB_BITS;
   localparam int unsigned NC_W     = $clog2(NIBS);
   localparam int unsigned CNT_SLOT = HDR_W - CRC_W;

   generate
      if (DATA_W % NIB_BITS != 0 || DATA_W < 8) begin : g_bad_data_w
         $error("DATA_W must be a multiple of 4 and at least 8");
      end
      if (HDR_W <= CRC_W || CNT_W > CNT_SLOT) begin : g_bad_hdr_w
         $error("count field does not fit above the check value in the header");
      end
      if (CNT_W < 1) begin : g_bad_cnt_w
         $error("CNT_W must be at least 1");
      end
   endgenerate

   crc_state_t        state_q;
   logic [NC_W-1:0]   nib_cnt_q;
   logic [CNT_W-1:0]  rem_q;
   logic [CNT_W-1:0]  cnt_q;
   logic [CNT_W-1:0]  res_cnt_q;
   logic [CRC_W-1:0]  res_q;
   logic              done_q;

   logic              accept;
   logic              step;
   logic              last_nib;
   logic [3:0]        nib;
   logic [CRC_W-1:0]  acc_nxt;

   assign q_ready_o = (state_q == ST_WAIT);
   assign accept    = q_ready_o && q_valid_i && !start_i;
   assign step      = (state_q == ST_SHIFT) && !start_i;
   assign last_nib  = (nib_cnt_q == NC_W'(NIBS - 1));

   cfgcrc_quad_shift #(
      .DATA_W    (DATA_W),
      .MSB_FIRST (MSB_FIRST)
   ) u_shift (
      .clk     (clk),
      .rst_n   (rst_n),
      .load_i  (accept),
      .data_i  (q_data_i),
      .shift_i (step),
      .nib_o   (nib)
   );

   cfgcrc_nib_engine #(
      .CRC_W (CRC_W)
   ) u_engine (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr_i     (start_i),
      .step_i    (step),
      .nib_i     (nib),
      .acc_nxt_o (acc_nxt)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q   <= ST_IDLE;
         nib_cnt_q <= '0;
         rem_q     <= '0;
         cnt_q     <= '0;
         res_cnt_q <= '0;
         res_q     <= '0;
         done_q    <= 1'b0;
      end else begin
         done_q <= 1'b0;
         if (start_i) begin
            cnt_q     <= count_i;
            rem_q     <= count_i;
            nib_cnt_q <= '0;
            if (count_i == '0) begin
               state_q   <= ST_IDLE;
               done_q    <= 1'b1;
               res_q     <= '0;
               res_cnt_q <= '0;
            end else begin
               state_q <= ST_WAIT;
            end
         end else begin
            unique case (state_q)
               ST_WAIT: begin
                  if (q_valid_i) begin
                     state_q   <= ST_SHIFT;
                     nib_cnt_q <= '0;
                  end
               end
               ST_SHIFT: begin
                  if (last_nib) begin
                     nib_cnt_q <= '0;
                     rem_q     <= rem_q - CNT_W'(1);
                     if (rem_q == CNT_W'(1)) begin
                        state_q   <= ST_IDLE;
                        done_q    <= 1'b1;
                        res_q     <= acc_nxt;
                        res_cnt_q <= cnt_q;
                     end else begin
                        state_q <= ST_WAIT;
                     end
                  end else begin
                     nib_cnt_q <= nib_cnt_q + NC_W'(1);
                  end
               end
               default: ;
            endcase
         end
      end
   end

   assign done_o = done_q;
   assign crc_o  = res_q;

   generate
      if (CNT_SLOT > CNT_W) begin : g_hdr_pad
         assign header_o = {{(CNT_SLOT - CNT_W){1'b0}}, res_cnt_q, res_q};
      end else begin : g_hdr_full
         assign header_o = {res_cnt_q, res_q};
      end
   endgenerate

   // R4: a handshake closes the input for the nibble cycles
   a_r4_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
      (q_valid_i && q_ready_o && !start_i) |=> !q_ready_o);

   // R5: done is a single-cycle pulse
   a_r5_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && !start_i) |=> !done_o);

   // R5: the result only moves together with done
   a_r5_crc_hold: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (done_o || $stable(crc_o)));

   // R7: an empty job finishes at once with zero
   a_r7_zero_count: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && count_i == '0) |=> (done_o && crc_o == '0));

   // R2: a real job opens the input next cycle
   a_r2_start_opens: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && count_i != '0) |=> (q_ready_o && !done_o));

endmodule

// File: tb/cfg_crc16_nib_test.sv
module cfg_crc16_nib_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start_i = 1'b0;
   logic [15:0] count_i = '0;
   logic        q_valid_i = 1'b0;
   logic [31:0] q_data_i = '0;
   logic        q_ready_o;
   logic        done_o;
   logic [15:0] crc_o;
   logic [31:0] header_o;

   int checks = 0;
   int fails  = 0;
   logic [31:0] mem [0:1023];

   always #5 clk = ~clk;

   cfg_crc16_nib uut (
      .clk       (clk),
      .rst_n     (rst_n),
      .start_i   (start_i),
      .count_i   (count_i),
      .q_valid_i (q_valid_i),
      .q_data_i  (q_data_i),
      .q_ready_o (q_ready_o),
      .done_o    (done_o),
      .crc_o     (crc_o),
      .header_o  (header_o)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   function automatic logic [15:0] model(input int off, input int n);
      longint unsigned c;
      longint unsigned nx;
      longint unsigned q;
      longint unsigned s;
      c = 0;
      for (int i = 0; i < n; i++) begin
         nx = c;
         q = {32'h0, mem[off + i]};
         for (int sh = 28; sh >= 0; sh -= 4) begin
            s  = ((nx >> 12) ^ (q >> sh)) & 64'hF;
            nx = (nx << 4) ^ (s << 12) ^ (s << 5) ^ s;
         end
         c = nx & 64'hFFFF;
      end
      return c[15:0];
   endfunction

   task automatic start_job(input int n);
      start_i = 1'b1;
      count_i = 16'(n);
      @(negedge clk);
      start_i = 1'b0;
      if (n != 0) begin
         chk(q_ready_o == 1'b1, "R2", "ready after start", {31'h0, q_ready_o}, 32'h1);
         chk(done_o == 1'b0, "R2", "no done after start", {31'h0, done_o}, 32'h0);
      end
   endtask

   // feed quadlets mem[off..off+n-1]; checks the busy window and the result
   task automatic feed(input int off, input int n, input int gap, input bit spam,
                       input string req);
      logic [15:0] exp;
      exp = model(off, n);
      for (int i = 0; i < n; i++) begin
         q_valid_i = 1'b1;
         q_data_i  = mem[off + i];
         while (!q_ready_o) @(negedge clk);
         @(negedge clk);
         q_valid_i = spam;
         q_data_i  = 32'hDEADBEEF;
         for (int k = 0; k < 8; k++) begin
            chk(q_ready_o == 1'b0 && done_o == 1'b0, "R4", "busy window",
                {30'h0, q_ready_o, done_o}, 32'h0);
            if (k < 7) @(negedge clk);
         end
         @(negedge clk);
         q_valid_i = 1'b0;
         if (i == n - 1) begin
            chk(done_o == 1'b1, "R5", "done after last nibble", {31'h0, done_o}, 32'h1);
            chk(crc_o == exp, req, "result", {16'h0, crc_o}, {16'h0, exp});
            chk(header_o == {16'(n), exp}, "R6", "header", header_o, {16'(n), exp});
            @(negedge clk);
            chk(done_o == 1'b0, "R5", "done one cycle", {31'h0, done_o}, 32'h0);
            chk(q_ready_o == 1'b0, "R5", "closed after done", {31'h0, q_ready_o}, 32'h0);
         end else begin
            chk(q_ready_o == 1'b1 && done_o == 1'b0, "R4", "reopen after 8",
                {30'h0, q_ready_o, done_o}, 32'h2);
            repeat (gap) @(negedge clk);
         end
      end
   endtask

   task automatic t_reset;
      chk(q_ready_o == 1'b0, "R1", "ready", {31'h0, q_ready_o}, 32'h0);
      chk(done_o == 1'b0, "R1", "done", {31'h0, done_o}, 32'h0);
      chk(crc_o == 16'h0, "R1", "crc", {16'h0, crc_o}, 32'h0);
      chk(header_o == 32'h0, "R1", "header", header_o, 32'h0);
   endtask

   task automatic t_single;
      mem[1000] = 32'h00000001;
      start_job(1);
      feed(1000, 1, 0, 1'b0, "R3");
      chk(crc_o == 16'h1021, "R3", "known value", {16'h0, crc_o}, 32'h1021);
      chk(header_o == 32'h00011021, "R6", "known header", header_o, 32'h00011021);
      mem[1000] = 32'h0;
      start_job(1);
      feed(1000, 1, 0, 1'b0, "R3");
   endtask

   task automatic t_zero;
      start_job(0);
      chk(done_o == 1'b1, "R7", "done", {31'h0, done_o}, 32'h1);
      chk(crc_o == 16'h0, "R7", "crc", {16'h0, crc_o}, 32'h0);
      chk(header_o == 32'h0, "R7", "header", header_o, 32'h0);
      chk(q_ready_o == 1'b0, "R7", "no ready", {31'h0, q_ready_o}, 32'h0);
      @(negedge clk);
      chk(done_o == 1'b0, "R7", "single pulse", {31'h0, done_o}, 32'h0);
   endtask

   task automatic t_gaps;
      start_job(6);
      feed(10, 6, 3, 1'b1, "R9");
      start_job(5);
      feed(20, 5, 0, 1'b1, "R4");
   endtask

   task automatic t_restart;
      q_valid_i = 1'b1;
      start_job(3);
      q_data_i = mem[100];
      @(negedge clk);
      q_valid_i = 1'b0;
      repeat (2) @(negedge clk);
      start_job(2);
      feed(200, 2, 1, 1'b0, "R8");
   endtask

   task automatic t_hold;
      logic [15:0] held;
      held = crc_o;
      repeat (6) @(negedge clk);
      chk(crc_o == held, "R5", "held after done", {16'h0, crc_o}, {16'h0, held});
   endtask

   task automatic t_speed_map;
      start_job(16'h3F1);
      feed(0, 16'h3F1, 0, 1'b0, "R10");
   endtask

   initial begin
      for (int i = 0; i < 1024; i++)
         mem[i] = (32'(i) * 32'h9E3779B1) ^ 32'h5A5A0F0F;
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_single();
      t_zero();
      t_gaps();
      t_hold();
      t_restart();
      t_speed_map();
      t_hold();
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

endmodule